// File: doc/BRIEF.md
# Greedy Grid Walk Controller

This block steers a point robot across a small occupancy grid, one cell per clock, from a start cell toward a destination cell. The grid arrives as a single flat bit vector with one bit per cell. A single-cycle start pulse captures the map, the start coordinate and the destination coordinate. The controller then walks greedily. On every cycle it first tries to close the column distance by one cell. If that cell is not usable, it tries to close the row distance by one cell instead. When neither move is possible, it stops.

Every cell the robot enters goes into a flat path log, in order of entry. The same cell is also set in a visited bitmap, and a count reports how many log entries are valid. The walk ends with `done` raised. `fail` is low when the destination was reached and high when the walk got stuck or ran out of cycles. The start cell must lie inside the grid. The destination may lie outside it, in which case the walk fails at the grid edge.

Top module: `gw_walker`

## Requirements
- R1: After reset, `done`, `fail`, `visit_count`, `path_log` and `visited` are all zero.
- R2: A start pulse accepted outside a walk loads the start cell as log entry 0 (row in bits [5:3], column in bits [2:0] of each 6-bit entry, entry k at bits [6k+5:6k]). It sets that cell's visited bit, sets the count to 1, clears `done` and `fail`, and zeroes all other log entries and bitmap bits.
- R3: Cell (r, c) is bit r*COLS+c of `map_in` and of `visited`. A map bit of 1 marks an obstacle, and the robot never enters such a cell.
- R4: While the column differs from the destination column, the robot moves one column toward it if that cell is inside the grid, free and not yet visited. It makes at most one move per clock.
- R5: When no column move is possible, because the column already matches or the cell is blocked, outside the grid or already visited, the robot moves one row toward the destination row under the same conditions.
- R6: Each entered cell is appended to the log at index `visit_count`, the count increments, and the cell's visited bit is set. The count always equals the number of set visited bits.
- R7: When the current cell equals the destination, `done` rises with `fail` low on the clock after the last move. If the start cell equals the destination, this happens on the clock after the start pulse.
- R8: When neither a column move nor a row move is possible, `done` and `fail` both rise on that clock.
- R9: A destination outside the grid never takes the robot outside the grid. The walk stops with `fail` high at the edge.
- R10: After MAX_CYC moves without reaching the destination, the walk ends with `done` and `fail` high. The log then holds MAX_CYC+1 entries.
- R11: A start pulse that arrives during a walk is ignored.
- R12: After the walk ends, all outputs hold their values until the next start pulse, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle pulse that captures inputs and begins a walk |
| map_in | input | ROWS*COLS | Occupancy map, 1 = obstacle |
| start_row | input | 3 | Start row |
| start_col | input | 3 | Start column |
| dst_row | input | 3 | Destination row |
| dst_col | input | 3 | Destination column |
| path_log | output | ROWS*COLS*6 | Visited coordinates in entry order, unused entries zero |
| visit_count | output | $clog2(ROWS*COLS+1) | Number of valid log entries |
| visited | output | ROWS*COLS | Visited-cell bitmap |
| done | output | 1 | Walk finished |
| fail | output | 1 | Walk finished without reaching the destination |

## Verification
Every start cell is paired with every destination coordinate the 3-bit fields can express, including rows and columns 6 and 7 outside the grid. Each pairing is run on four maps: an empty grid, a vertical wall, a diagonal-stripe pattern and a scattered pattern. The empty grid shows the column-before-row ordering and the exact move latency. The walls and patterns tell apart a correct fallback to the row axis from a wrong axis choice or a missed obstacle. They also show where the stuck detection fires. The out-of-grid destinations separate bounds checking from a mere comparison with the destination. A second instance with a three-move limit exposes the cycle limit. Directed runs cover start pulses during a walk and input changes after it ends.

// File: rtl/gw_pkg.sv
package gw_pkg;

    localparam int CW = 3;

    typedef struct packed {
        logic [CW-1:0] row;
        logic [CW-1:0] col;
    } coord_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_DONE = 2'd2
    } state_t;

    typedef struct packed {
        logic   at_dst;
        logic   advance;
        coord_t nxt;
    } step_t;

    function automatic logic one_apart(input coord_t a, input coord_t b);
        logic same_row, same_col, col_adj, row_adj;
        same_row = (a.row == b.row);
        same_col = (a.col == b.col);
        col_adj  = ({1'b0, a.col} == {1'b0, b.col} + 4'd1) || ({1'b0, b.col} == {1'b0, a.col} + 4'd1);
        row_adj  = ({1'b0, a.row} == {1'b0, b.row} + 4'd1) || ({1'b0, b.row} == {1'b0, a.row} + 4'd1);
        return (same_row && col_adj) || (same_col && row_adj);
    endfunction

endpackage

// File: rtl/gw_step_sel.sv
module gw_step_sel
    import gw_pkg::*;
#(
    parameter int ROWS = 6,
    parameter int COLS = 6,
    localparam int CELLS = ROWS * COLS
) (
    input  coord_t           cur,
    input  coord_t           dst,
    input  logic [CELLS-1:0] map_bits,
    input  logic [CELLS-1:0] seen,
    output step_t            step
);

    function automatic logic cell_open(input logic [CELLS-1:0] m, input logic [CELLS-1:0] s,
                                       input logic [CW:0] r, input logic [CW:0] c);
        int idx;
        if (int'(r) >= ROWS || int'(c) >= COLS) return 1'b0;
        idx = int'(r) * COLS + int'(c);
        return !m[idx] && !s[idx];
    endfunction

    logic [CW:0] col_cand, row_cand;
    logic        col_want, row_want, col_ok, row_ok;

    always_comb begin
        col_want = (dst.col != cur.col);
        row_want = (dst.row != cur.row);
        col_cand = (dst.col > cur.col) ? {1'b0, cur.col} + (CW+1)'(1) : {1'b0, cur.col} - (CW+1)'(1);
        row_cand = (dst.row > cur.row) ? {1'b0, cur.row} + (CW+1)'(1) : {1'b0, cur.row} - (CW+1)'(1);
        col_ok   = col_want && cell_open(map_bits, seen, {1'b0, cur.row}, col_cand);
        row_ok   = row_want && cell_open(map_bits, seen, row_cand, {1'b0, cur.col});

        step.at_dst  = (cur == dst);
        step.advance = col_ok || row_ok;
        step.nxt     = cur;
        if (col_ok) begin
            step.nxt.col = col_cand[CW-1:0];
        end else if (row_ok) begin
            step.nxt.row = row_cand[CW-1:0];
        end
    end

endmodule

// File: rtl/gw_path_log.sv
module gw_path_log
    import gw_pkg::*;
#(
    parameter int ROWS = 6,
    parameter int COLS = 6,
    localparam int CELLS = ROWS * COLS,
    localparam int EW    = 2 * CW,
    localparam int LOG_W = CELLS * EW,
    localparam int CNTW  = $clog2(CELLS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             append,
    input  coord_t           pos,
    output logic [LOG_W-1:0] path_q,
    output logic [CELLS-1:0] seen_q,
    output logic [CNTW-1:0]  count_q
);

    logic [CELLS-1:0] pos_bit;
    logic             room;

    always_comb begin
        pos_bit = '0;
        if (int'(pos.row) < ROWS && int'(pos.col) < COLS)
            pos_bit[int'(pos.row) * COLS + int'(pos.col)] = 1'b1;
        room = (int'(count_q) < CELLS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q  <= '0;
            seen_q  <= '0;
            count_q <= '0;
        end else if (init) begin
            path_q         <= '0;
            path_q[0 +: EW] <= pos;
            seen_q         <= pos_bit;
            count_q        <= CNTW'(1);
        end else if (append && room) begin
            path_q[int'(count_q) * EW +: EW] <= pos;
            seen_q  <= seen_q | pos_bit;
            count_q <= count_q + CNTW'(1);
        end
    end

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(count_q) <= CELLS) else $error("count out of range"); // R6

    AST_COUNT_GROWS: assert property (@(posedge clk) disable iff (rst)
        (append && room && !init) |=> count_q == $past(count_q) + CNTW'(1))
        else $error("count did not grow"); // R6

    AST_BITMAP_MATCH: assert property (@(posedge clk) disable iff (rst)
        int'(count_q) == $countones(seen_q)) else $error("bitmap and count disagree"); // R6

endmodule

// File: rtl/gw_walker.sv
module gw_walker
    import gw_pkg::*;
#(
    parameter int ROWS    = 6,
    parameter int COLS    = 6,
    parameter int MAX_CYC = 36,
    localparam int CELLS = ROWS * COLS,
    localparam int LOG_W = CELLS * 2 * CW,
    localparam int CNTW  = $clog2(CELLS + 1),
    localparam int CYW   = $clog2(MAX_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CELLS-1:0] map_in,
    input  logic [CW-1:0]    start_row,
    input  logic [CW-1:0]    start_col,
    input  logic [CW-1:0]    dst_row,
    input  logic [CW-1:0]    dst_col,
    output logic [LOG_W-1:0] path_log,
    output logic [CNTW-1:0]  visit_count,
    output logic [CELLS-1:0] visited,
    output logic             done,
    output logic             fail
);

    state_t           state;
    coord_t           cur, dst_q, log_pos;
    logic [CELLS-1:0] map_q;
    logic [CYW-1:0]   cyc;
    logic             accept, at_limit, mv;
    step_t            step;

    gw_step_sel #(.ROWS(ROWS), .COLS(COLS)) u_step (
        .cur      (cur),
        .dst      (dst_q),
        .map_bits (map_q),
        .seen     (visited),
        .step     (step)
    );

    always_comb begin
        accept   = start && (state != ST_WALK);
        at_limit = (cyc == CYW'(MAX_CYC));
        mv       = (state == ST_WALK) && !step.at_dst && !at_limit && step.advance;
        log_pos  = accept ? coord_t'{row: start_row, col: start_col} : step.nxt;
    end

    gw_path_log #(.ROWS(ROWS), .COLS(COLS)) u_log (
        .clk     (clk),
        .rst     (rst),
        .init    (accept),
        .append  (mv),
        .pos     (log_pos),
        .path_q  (path_log),
        .seen_q  (visited),
        .count_q (visit_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
            dst_q <= '0;
            map_q <= '0;
            cyc   <= '0;
            fail  <= 1'b0;
        end else if (accept) begin
            state <= ST_WALK;
            cur   <= coord_t'{row: start_row, col: start_col};
            dst_q <= coord_t'{row: dst_row, col: dst_col};
            map_q <= map_in;
            cyc   <= '0;
            fail  <= 1'b0;
        end else if (state == ST_WALK) begin
            if (step.at_dst) begin
                state <= ST_DONE;
            end else if (at_limit || !step.advance) begin
                state <= ST_DONE;
                fail  <= 1'b1;
            end else begin
                cur <= step.nxt;
                cyc <= cyc + CYW'(1);
            end
        end
    end

    assign done = (state == ST_DONE);

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        mv |=> one_apart(cur, $past(cur))) else $error("move was not one cell"); // R4

    AST_FREE_CELL: assert property (@(posedge clk) disable iff (rst)
        mv |=> !map_q[int'(cur.row) * COLS + int'(cur.col)]) else $error("entered obstacle"); // R3

    AST_IN_GRID: assert property (@(posedge clk) disable iff (rst)
        mv |=> (int'(cur.row) < ROWS && int'(cur.col) < COLS)) else $error("left the grid"); // R9

    AST_CYCLE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WALK) |-> int'(cyc) <= MAX_CYC) else $error("cycle limit passed"); // R10

    AST_WALK_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WALK && start) |=> $stable(dst_q)) else $error("start taken mid-walk"); // R11

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && !start) |=> (done && $stable(fail) && $stable(visit_count) && $stable(path_log)))
        else $error("result changed after done"); // R12

endmodule

// File: tb/gw_walker_bench.sv
module gw_walker_bench;
    localparam int ROWS  = 6;
    localparam int COLS  = 6;
    localparam int CELLS = ROWS * COLS;
    localparam int LOG_W = CELLS * 6;
    localparam int CNTW  = $clog2(CELLS + 1);
    localparam int LIM_A = 36;
    localparam int LIM_B = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_a = 1'b0, start_b = 1'b0;
    logic [CELLS-1:0] map_in = '0;
    logic [2:0] start_row = '0, start_col = '0, dst_row = '0, dst_col = '0;
    logic [LOG_W-1:0] log_a, log_b;
    logic [CNTW-1:0]  cnt_a, cnt_b;
    logic [CELLS-1:0] vis_a, vis_b;
    logic done_a, done_b, fail_a, fail_b;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gw_walker #(.ROWS(ROWS), .COLS(COLS), .MAX_CYC(LIM_A)) u_gw_walker (
        .clk(clk), .rst(rst), .start(start_a), .map_in(map_in),
        .start_row(start_row), .start_col(start_col), .dst_row(dst_row), .dst_col(dst_col),
        .path_log(log_a), .visit_count(cnt_a), .visited(vis_a), .done(done_a), .fail(fail_a));

    gw_walker #(.ROWS(ROWS), .COLS(COLS), .MAX_CYC(LIM_B)) u_short (
        .clk(clk), .rst(rst), .start(start_b), .map_in(map_in),
        .start_row(start_row), .start_col(start_col), .dst_row(dst_row), .dst_col(dst_col),
        .path_log(log_b), .visit_count(cnt_b), .visited(vis_b), .done(done_b), .fail(fail_b));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic bit open_cell(input logic [CELLS-1:0] m, input logic [CELLS-1:0] v,
                                     input int r, input int c);
        if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 1'b0;
        return !m[r*COLS+c] && !v[r*COLS+c];
    endfunction

    // Reference walk built from the requirements
    task automatic ref_walk(input logic [CELLS-1:0] m, input int sr, input int sc,
                            input int dr, input int dc, input int lim,
                            output logic [LOG_W-1:0] lg, output int cnt,
                            output logic [CELLS-1:0] vis, output bit f, output int lat);
        int r, c, steps;
        bit moved;
        r = sr; c = sc; steps = 0;
        lg = '0; vis = '0; cnt = 1; f = 1'b0; lat = 0;
        lg[5:0] = {3'(r), 3'(c)};
        vis[r*COLS+c] = 1'b1;
        for (int it = 0; it < 100; it++) begin
            if (r == dr && c == dc) begin f = 1'b0; lat = steps + 1; break; end
            if (steps == lim) begin f = 1'b1; lat = steps + 1; break; end
            moved = 1'b0;
            if (dc != c) begin
                if (open_cell(m, vis, r, (dc > c) ? c + 1 : c - 1)) begin
                    c = (dc > c) ? c + 1 : c - 1; moved = 1'b1;
                end
            end
            if (!moved && dr != r) begin
                if (open_cell(m, vis, (dr > r) ? r + 1 : r - 1, c)) begin
                    r = (dr > r) ? r + 1 : r - 1; moved = 1'b1;
                end
            end
            if (!moved) begin f = 1'b1; lat = steps + 1; break; end
            steps++;
            lg[cnt*6 +: 6] = {3'(r), 3'(c)};
            vis[r*COLS+c] = 1'b1;
            cnt++;
        end
    endtask

    task automatic run_case(input bit use_b, input logic [CELLS-1:0] m,
                            input int sr, input int sc, input int dr, input int dc,
                            input bit hit_mid);
        logic [LOG_W-1:0] e_log;
        logic [CELLS-1:0] e_vis;
        int e_cnt, e_lat, k;
        bit e_f, d;
        string rq;
        ref_walk(m, sr, sc, dr, dc, use_b ? LIM_B : LIM_A, e_log, e_cnt, e_vis, e_f, e_lat);
        @(negedge clk);
        map_in = m; start_row = 3'(sr); start_col = 3'(sc); dst_row = 3'(dr); dst_col = 3'(dc);
        if (use_b) start_b = 1'b1; else start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0; start_b = 1'b0;
        k = 0;
        d = use_b ? done_b : done_a;
        while (!d && k < 60) begin
            if (hit_mid && k == 2) begin
                start_row = 3'd4; start_col = 3'd1; dst_row = 3'd0; dst_col = 3'd0;
                start_a = 1'b1;
            end else begin
                start_a = 1'b0;
            end
            @(negedge clk);
            k++;
            d = use_b ? done_b : done_a;
        end
        start_a = 1'b0;
        if (dr >= ROWS || dc >= COLS) rq = "R9";
        else if (use_b && e_f) rq = "R10";
        else if (hit_mid) rq = "R11";
        else if (e_f) rq = "R8";
        else rq = "R7";
        check(d && k == e_lat, rq, "done latency", 256'(k), 256'(e_lat));
        check((use_b ? fail_b : fail_a) == e_f, rq, "fail flag",
              256'(use_b ? fail_b : fail_a), 256'(e_f));
        check(int'(use_b ? cnt_b : cnt_a) == e_cnt, "R6", "visit count",
              256'(use_b ? cnt_b : cnt_a), 256'(e_cnt));
        check((use_b ? log_b : log_a) == e_log, "R4 R5", "path log",
              256'(use_b ? log_b : log_a), 256'(e_log));
        check((use_b ? vis_b : vis_a) == e_vis, "R3 R6", "visited map",
              256'(use_b ? vis_b : vis_a), 256'(e_vis));
    endtask

    function automatic logic [CELLS-1:0] make_map(input int sel);
        logic [CELLS-1:0] m;
        m = '0;
        for (int i = 0; i < CELLS; i++) begin
            case (sel)
                1: m[i] = ((i % COLS) == 3) && ((i / COLS) >= 1) && ((i / COLS) <= 4);
                2: m[i] = (((i / COLS) + (i % COLS)) % 4) == 3;
                3: m[i] = ((i * 7 + 3) % 5) == 0;
                default: m[i] = 1'b0;
            endcase
        end
        return m;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        report();
    end

    initial begin
        logic [LOG_W-1:0] h_log;
        logic [CNTW-1:0]  h_cnt;
        logic [CELLS-1:0] h_vis;
        bit h_f;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!done_a && !fail_a && cnt_a == '0 && log_a == '0 && vis_a == '0, "R1", "reset outputs",
              256'({done_a, fail_a, cnt_a}), 256'(0));

        // R2: state right after the start pulse
        map_in = '0; start_row = 3'd2; start_col = 3'd4; dst_row = 3'd5; dst_col = 3'd0;
        start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        check(cnt_a == CNTW'(1) && log_a == LOG_W'({3'd2, 3'd4}) && vis_a == (CELLS'(1) << 16) && !done_a,
              "R2", "start load", 256'(log_a), 256'({3'd2, 3'd4}));
        while (!done_a) @(negedge clk);

        // R11: start pulse during a walk is ignored
        run_case(1'b0, '0, 0, 0, 5, 5, 1'b1);

        // R12: outputs hold after done while inputs change
        h_log = log_a; h_cnt = cnt_a; h_vis = vis_a; h_f = fail_a;
        map_in = '1; start_row = 3'd3; dst_col = 3'd1;
        repeat (5) @(negedge clk);
        check(done_a && log_a == h_log && cnt_a == h_cnt && vis_a == h_vis && fail_a == h_f,
              "R12", "hold after done", 256'(cnt_a), 256'(h_cnt));

        // Sweep: every start against every 3-bit destination on four maps (R3..R9)
        for (int sel = 0; sel < 4; sel++)
            for (int s = 0; s < CELLS; s++)
                for (int dr = 0; dr < 8; dr++)
                    for (int dc = 0; dc < 8; dc++)
                        run_case(1'b0, make_map(sel), s / COLS, s % COLS, dr, dc, 1'b0);

        // R10: short-limit instance on the empty grid
        for (int s = 0; s < CELLS; s++)
            for (int d = 0; d < CELLS; d++)
                run_case(1'b1, '0, s / COLS, s % COLS, d / COLS, d % COLS, 1'b0);

        report();
    end

endmodule